// File: doc/BRIEF.md
# Windowed Adapter Command and Status Core

This block is the host-side control core of a simple Ethernet adapter. Software issues every operation as one 16-bit command word written to a fixed offset. The word holds a 5-bit opcode and an 11-bit argument. Software reads a 16-bit status word back from that same offset. The core keeps the following state:

- the selected register window;
- a latched set of interrupt-cause bits, which are cleared by an acknowledge command that carries a bit mask;
- the interrupt mask, the read-zero mask and the receive filter;
- the receive and transmit enable flags.

Logic outside the core reports events on a pulse input. The core drives one interrupt request output.

Window 5 reads back the interrupt mask, the read-zero mask and the receive filter. A global-reset command raises a busy flag for a programmable number of clocks. While the flag is high, all later commands are discarded. When the flag falls, every register returns to its reset value.

Top module: `nic_cmd_core`

## Requirements
- R1: After `rst_n` is released, the status word reads 0x0000, offset 0x0F reads 0, `irq`, `rx_enable` and `tx_enable` are low, and the window-5 offsets 0x08, 0x0A and 0x0C read 0.
- R2: A write counts as a command only when `wr_off` is 0x0E. The opcode is `wr_data[15:11]` and the argument is `wr_data[10:0]`. Writes at any other offset change nothing.
- R3: Opcode 1 selects window `arg[2:0]` from the next cycle on. Status bits 15..13 and a read at offset 0x0F both report the current window.
- R4: A pulse on `evt_in[i]` sets status bit i+1 on the next cycle: 1 adapter failure, 2 TX complete, 3 TX available, 4 RX complete, 5 RX early, 6 interrupt requested, 7 update statistics. The bit stays set until it is acknowledged or reset.
- R5: Opcode 13 clears each status bit 7..1 whose bit is set in `arg[7:1]`. When an event for a bit arrives in the same cycle as its acknowledge, the event wins and the bit stays set.
- R6: Opcode 12 sets status bit 6.
- R7: Opcode 4 enables reception and opcode 3 disables it. Opcode 9 enables transmission and opcode 10 disables it. Status bits 11..8 always read 0.
- R8: Opcode 14 loads the interrupt mask from `arg[7:0]` and opcode 15 loads the read-zero mask from `arg[7:0]`. Opcode 16 loads the receive filter from `arg[3:0]`: bit 0 individual, bit 1 group, bit 2 broadcast, bit 3 all. In window 5 these read back at offsets 0x0A, 0x0C and 0x08. In any other window those offsets read 0.
- R9: `irq` is high exactly when status bits 7..1 AND interrupt-mask bits 7..1 is nonzero. Status bit 0 equals `irq`.
- R10: Opcode 0 raises status bit 12 for RESET_CYCLES clocks, starting the cycle after the write. Commands issued in that time have no effect. When the bit falls, every register holds its reset value.
- R11: Opcodes with no defined action, such as 5 and 2, change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_off | input | 4 | Write offset |
| wr_data | input | 16 | Write data (command word at offset 0x0E) |
| rd_off | input | 4 | Read offset |
| rd_data | output | 16 | Read data, combinational from `rd_off` |
| evt_in | input | 7 | Event pulses; bit i sets status bit i+1 |
| irq | output | 1 | Interrupt request |
| rx_enable | output | 1 | Receiver enabled |
| tx_enable | output | 1 | Transmitter enabled |

## Verification
Each piece of state reaches the ports in one cycle. A wrong window number appears in the next status read, both in bits 15..13 and at offset 0x0F. A wrong latched cause bit or mask bit shows up at once as a wrong `irq` level, because `irq` is combinational from those registers. A fault in the reset counter is visible as a busy pulse that is one cycle too long or too short. It can also show as a command that takes effect while busy is high, or as state that survives the end of the busy window.

// File: rtl/nic_cmd_pkg.sv
package nic_cmd_pkg;

  localparam int CMD_W  = 16;
  localparam int OP_W   = 5;
  localparam int ARG_W  = CMD_W - OP_W;
  localparam int WIN_W  = 3;
  localparam int MASK_W = 8;
  localparam int FILT_W = 4;
  localparam int EVT_W  = 7;

  localparam logic [OP_W-1:0] OP_GRESET = 5'd0;
  localparam logic [OP_W-1:0] OP_WINSEL = 5'd1;
  localparam logic [OP_W-1:0] OP_RX_OFF = 5'd3;
  localparam logic [OP_W-1:0] OP_RX_ON  = 5'd4;
  localparam logic [OP_W-1:0] OP_TX_ON  = 5'd9;
  localparam logic [OP_W-1:0] OP_TX_OFF = 5'd10;
  localparam logic [OP_W-1:0] OP_IRQREQ = 5'd12;
  localparam logic [OP_W-1:0] OP_ACK    = 5'd13;
  localparam logic [OP_W-1:0] OP_IMASK  = 5'd14;
  localparam logic [OP_W-1:0] OP_RZMASK = 5'd15;
  localparam logic [OP_W-1:0] OP_FILTER = 5'd16;

  localparam logic [3:0] OFF_CMD   = 4'hE;
  localparam logic [3:0] OFF_WIN   = 4'hF;
  localparam logic [3:0] OFF_FILT  = 4'h8;
  localparam logic [3:0] OFF_IMASK = 4'hA;
  localparam logic [3:0] OFF_RZ    = 4'hC;
  localparam logic [WIN_W-1:0] SETUP_WIN = 3'd5;

  localparam int REQ_BIT = 6;

  typedef struct packed {
    logic             greset;
    logic             win_sel;
    logic             rx_off;
    logic             rx_on;
    logic             tx_on;
    logic             tx_off;
    logic             irq_req;
    logic             ack;
    logic             ld_imask;
    logic             ld_rzmask;
    logic             ld_filter;
    logic [ARG_W-1:0] arg;
  } cmd_strobe_t;

  function automatic logic [OP_W-1:0] op_of(input logic [CMD_W-1:0] w);
    return w[CMD_W-1:ARG_W];
  endfunction

  function automatic logic [ARG_W-1:0] arg_of(input logic [CMD_W-1:0] w);
    return w[ARG_W-1:0];
  endfunction

  // interrupt pending: latched causes 7..1 qualified by mask 7..1
  function automatic logic irq_pending(input logic [7:1] st,
                                       input logic [MASK_W-1:0] m);
    return |(st & m[7:1]);
  endfunction

  // next cause set: acknowledge first, new events override it
  function automatic logic [7:1] cause_next(input logic [7:1] st,
                                            input logic [7:1] ev,
                                            input logic       ack,
                                            input logic [7:1] ack_mask,
                                            input logic       req);
    logic [7:1] n;
    n = ack ? (st & ~ack_mask) : st;
    n = n | ev;
    if (req) n[REQ_BIT] = 1'b1;
    return n;
  endfunction

  function automatic logic [CMD_W-1:0] status_word(input logic [WIN_W-1:0] win,
                                                   input logic busy,
                                                   input logic [7:1] st,
                                                   input logic irq);
    return {win, busy, 4'b0000, st, irq};
  endfunction

endpackage

// File: rtl/nic_cmd_decode.sv
module nic_cmd_decode
  import nic_cmd_pkg::*;
(
  input  logic             wr_en,
  input  logic [3:0]       wr_off,
  input  logic [CMD_W-1:0] wr_data,
  input  logic             busy,
  output cmd_strobe_t      cmd
);
  logic            accept;
  logic [OP_W-1:0] op;

  assign accept = wr_en && (wr_off == OFF_CMD) && !busy;
  assign op     = op_of(wr_data);

  always_comb begin
    cmd           = '0;
    cmd.arg       = arg_of(wr_data);
    cmd.greset    = accept && (op == OP_GRESET);
    cmd.win_sel   = accept && (op == OP_WINSEL);
    cmd.rx_off    = accept && (op == OP_RX_OFF);
    cmd.rx_on     = accept && (op == OP_RX_ON);
    cmd.tx_on     = accept && (op == OP_TX_ON);
    cmd.tx_off    = accept && (op == OP_TX_OFF);
    cmd.irq_req   = accept && (op == OP_IRQREQ);
    cmd.ack       = accept && (op == OP_ACK);
    cmd.ld_imask  = accept && (op == OP_IMASK);
    cmd.ld_rzmask = accept && (op == OP_RZMASK);
    cmd.ld_filter = accept && (op == OP_FILTER);
  end
endmodule

// File: rtl/nic_reset_seq.sv
module nic_reset_seq #(
  parameter int RESET_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (RESET_CYCLES > 1) ? $clog2(RESET_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RESET_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done = busy && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        cnt_q <= CNT_LOAD;
      end
    end else if (done) begin
      busy <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/nic_ctrl_regs.sv
module nic_ctrl_regs
  import nic_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_strobe_t       cmd,
  input  logic              clr,
  output logic [WIN_W-1:0]  window,
  output logic [MASK_W-1:0] imask,
  output logic [MASK_W-1:0] rzmask,
  output logic [FILT_W-1:0] filter,
  output logic              rx_en,
  output logic              tx_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      window <= '0;
      imask  <= '0;
      rzmask <= '0;
      filter <= '0;
      rx_en  <= 1'b0;
      tx_en  <= 1'b0;
    end else if (clr) begin
      window <= '0;
      imask  <= '0;
      rzmask <= '0;
      filter <= '0;
      rx_en  <= 1'b0;
      tx_en  <= 1'b0;
    end else begin
      if (cmd.win_sel)   window <= cmd.arg[WIN_W-1:0];
      if (cmd.ld_imask)  imask  <= cmd.arg[MASK_W-1:0];
      if (cmd.ld_rzmask) rzmask <= cmd.arg[MASK_W-1:0];
      if (cmd.ld_filter) filter <= cmd.arg[FILT_W-1:0];
      if (cmd.rx_on)       rx_en <= 1'b1;
      else if (cmd.rx_off) rx_en <= 1'b0;
      if (cmd.tx_on)       tx_en <= 1'b1;
      else if (cmd.tx_off) tx_en <= 1'b0;
    end
  end
endmodule

// File: rtl/nic_status_latch.sv
module nic_status_latch
  import nic_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [EVT_W-1:0]  evt,
  input  logic              ack,
  input  logic [7:1]        ack_mask,
  input  logic              req,
  input  logic [MASK_W-1:0] imask,
  output logic [7:1]        stat,
  output logic              irq
);
  logic [7:1] ev_map;
  logic [7:1] stat_n;

  assign ev_map = evt;
  assign stat_n = cause_next(stat, ev_map, ack, ack_mask, req);
  assign irq    = irq_pending(stat, imask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stat <= '0;
    else if (clr) stat <= '0;
    else          stat <= stat_n;
  end
endmodule

// File: rtl/nic_cmd_core.sv
module nic_cmd_core
  import nic_cmd_pkg::*;
#(
  parameter int RESET_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_off,
  input  logic [15:0] wr_data,
  input  logic [3:0]  rd_off,
  output logic [15:0] rd_data,
  input  logic [6:0]  evt_in,
  output logic        irq,
  output logic        rx_enable,
  output logic        tx_enable
);
  cmd_strobe_t       cmd_s;
  logic              busy;
  logic              reset_fire;
  logic [WIN_W-1:0]  window;
  logic [MASK_W-1:0] imask;
  logic [MASK_W-1:0] rzmask;
  logic [FILT_W-1:0] filter;
  logic [7:1]        stat;
  logic              in_setup;

  nic_cmd_decode u_dec (
    .wr_en  (wr_en),
    .wr_off (wr_off),
    .wr_data(wr_data),
    .busy   (busy),
    .cmd    (cmd_s)
  );

  nic_reset_seq #(.RESET_CYCLES(RESET_CYCLES)) u_rst (
    .clk  (clk),
    .rst_n(rst_n),
    .start(cmd_s.greset),
    .busy (busy),
    .done (reset_fire)
  );

  nic_ctrl_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (cmd_s),
    .clr   (reset_fire),
    .window(window),
    .imask (imask),
    .rzmask(rzmask),
    .filter(filter),
    .rx_en (rx_enable),
    .tx_en (tx_enable)
  );

  nic_status_latch u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (reset_fire),
    .evt     (evt_in),
    .ack     (cmd_s.ack),
    .ack_mask(cmd_s.arg[7:1]),
    .req     (cmd_s.irq_req),
    .imask   (imask),
    .stat    (stat),
    .irq     (irq)
  );

  assign in_setup = (window == SETUP_WIN);

  always_comb begin
    rd_data = '0;
    unique case (rd_off)
      OFF_CMD:   rd_data = status_word(window, busy, stat, irq);
      OFF_WIN:   rd_data = {{(CMD_W-WIN_W){1'b0}}, window};
      OFF_FILT:  if (in_setup) rd_data = {{(CMD_W-FILT_W){1'b0}}, filter};
      OFF_IMASK: if (in_setup) rd_data = {{(CMD_W-MASK_W){1'b0}}, imask};
      OFF_RZ:    if (in_setup) rd_data = {{(CMD_W-MASK_W){1'b0}}, rzmask};
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/nic_cmd_core_chk.sv
module nic_cmd_core_chk
  import nic_cmd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [3:0]        wr_off,
  input logic [6:0]        evt_in,
  input cmd_strobe_t       cmd_s,
  input logic              busy,
  input logic              reset_fire,
  input logic [WIN_W-1:0]  window,
  input logic [MASK_W-1:0] imask,
  input logic [7:1]        stat,
  input logic              irq,
  input logic              rx_enable,
  input logic              tx_enable
);
  // R3
  win_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_s.win_sel |=> (window == $past(cmd_s.arg[2:0])));

  // R4
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_s.ack && !reset_fire) |=> ((stat & $past(stat)) == $past(stat)));

  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_s.ack && evt_in == '0) |=> ((stat & $past(cmd_s.arg[7:1])) == '0));

  // R6
  irq_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_s.irq_req |=> stat[6]);

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imask == '0) |-> !irq);

  // R10
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && wr_off == OFF_CMD && !reset_fire)
      |=> ($stable(window) && $stable(imask) && $stable(rx_enable)));

  // R10
  reset_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_fire |=> (!busy && window == '0 && imask == '0 && stat == '0
                    && !rx_enable && !tx_enable));
endmodule

bind nic_cmd_core nic_cmd_core_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_off    (wr_off),
  .evt_in    (evt_in),
  .cmd_s     (cmd_s),
  .busy      (busy),
  .reset_fire(reset_fire),
  .window    (window),
  .imask     (imask),
  .stat      (stat),
  .irq       (irq),
  .rx_enable (rx_enable),
  .tx_enable (tx_enable)
);

// File: tb/nic_cmd_core_test.sv
`timescale 1ns/1ps
module nic_cmd_core_test;
  localparam int RC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_off = 4'h0;
  logic [15:0] wr_data = 16'h0;
  logic [3:0]  rd_off = 4'hE;
  logic [15:0] rd_data;
  logic [6:0]  evt_in = 7'h0;
  logic        irq, rx_enable, tx_enable;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nic_cmd_core #(.RESET_CYCLES(RC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off),
    .wr_data(wr_data), .rd_off(rd_off), .rd_data(rd_data),
    .evt_in(evt_in), .irq(irq), .rx_enable(rx_enable), .tx_enable(tx_enable)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // one write at a given offset, returns at the falling edge after it lands
  task automatic wr(input logic [3:0] off, input logic [15:0] d);
    wr_en = 1'b1; wr_off = off; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_off = 4'h0; wr_data = 16'h0;
  endtask

  task automatic cmd(input int op, input int arg);
    wr(4'hE, 16'((op << 11) | (arg & 16'h07FF)));
  endtask

  task automatic rd(input logic [3:0] off, output logic [15:0] v);
    rd_off = off; #0.5; v = rd_data;
  endtask

  task automatic pulse(input logic [6:0] e);
    evt_in = e; @(posedge clk); @(negedge clk); evt_in = 7'h0;
  endtask

  task automatic t_reset_state;
    logic [15:0] v;
    rd(4'hE, v); check("R1 status", v, 16'h0000);
    rd(4'hF, v); check("R1 window", v, 16'h0000);
    check("R1 irq/rx/tx", {13'b0, irq, rx_enable, tx_enable}, 16'h0);
    cmd(1, 5);
    rd(4'h8, v); check("R1 filter", v, 16'h0);
    rd(4'hA, v); check("R1 imask", v, 16'h0);
    rd(4'hC, v); check("R1 rzmask", v, 16'h0);
    cmd(1, 0);
  endtask

  task automatic t_window;
    logic [15:0] v;
    cmd(1, 16'h7F3);          // only arg[2:0]=3 counts
    rd(4'hE, v); check("R3 status window", {13'b0, v[15:13]}, 16'd3);
    rd(4'hF, v); check("R3 offset 0F", v, 16'd3);
    cmd(1, 7);
    rd(4'hF, v); check("R3 window 7", v, 16'd7);
    wr(4'hA, 16'h0805);        // R2: not the command offset
    rd(4'hF, v); check("R2 other offset ignored", v, 16'd7);
    cmd(1, 0);
  endtask

  task automatic t_events_ack;
    logic [15:0] v;
    pulse(7'b0001001);         // status bits 1 and 4
    rd(4'hE, v); check("R4 latch", v, 16'h0012);
    repeat (3) @(negedge clk);
    rd(4'hE, v); check("R4 hold", v, 16'h0012);
    cmd(13, 16'h0002);
    rd(4'hE, v); check("R5 ack bit1", v, 16'h0010);
    // event and acknowledge of bit 3 in the same cycle
    pulse(7'b0000100);
    evt_in = 7'b0000100;
    cmd(13, 16'h0008);
    evt_in = 7'h0;
    rd(4'hE, v); check("R5 event wins", v, 16'h0018);
    cmd(13, 16'h00FF);
    rd(4'hE, v); check("R5 ack all", v, 16'h0000);
  endtask

  task automatic t_irq;
    logic [15:0] v;
    cmd(14, 16'h0004);         // mask TX complete
    pulse(7'b0001000);         // RX complete, not masked
    check("R9 unmasked cause", {15'b0, irq}, 16'h0);
    pulse(7'b0000010);         // TX complete
    check("R9 irq high", {15'b0, irq}, 16'h1);
    rd(4'hE, v); check("R9 bit0 mirrors", v, 16'h0015);
    cmd(13, 16'h0004);
    check("R9 irq cleared", {15'b0, irq}, 16'h0);
    cmd(12, 0);
    rd(4'hE, v); check("R6 request bit", v, 16'h0050);
    cmd(14, 16'h0040);
    check("R6 R9 request irq", {15'b0, irq}, 16'h1);
    cmd(13, 16'h00FE);
    cmd(14, 0);
  endtask

  task automatic t_enables;
    logic [15:0] v;
    cmd(4, 16'h7FF);
    check("R7 rx on", {15'b0, rx_enable}, 16'h1);
    cmd(9, 0);
    check("R7 tx on", {15'b0, tx_enable}, 16'h1);
    cmd(3, 0);
    check("R7 rx off", {14'b0, rx_enable, tx_enable}, 16'h1);
    cmd(10, 0);
    check("R7 tx off", {15'b0, tx_enable}, 16'h0);
    pulse(7'h7F);
    rd(4'hE, v); check("R7 bits 11..8 zero", {12'b0, v[11:8]}, 16'h0);
    cmd(13, 16'h00FF);
  endtask

  task automatic t_masks;
    logic [15:0] v;
    cmd(14, 16'h7A5);
    cmd(15, 16'h33C);
    cmd(16, 16'h7F6);
    rd(4'hA, v); check("R8 imask hidden outside w5", v, 16'h0);
    cmd(1, 5);
    rd(4'hA, v); check("R8 imask", v, 16'h00A5);
    rd(4'hC, v); check("R8 rzmask", v, 16'h003C);
    rd(4'h8, v); check("R8 filter", v, 16'h0006);
    cmd(16, 16'h0009);         // individual + all
    rd(4'h8, v); check("R8 filter 2", v, 16'h0009);
  endtask

  task automatic t_ignored;
    logic [15:0] v;
    cmd(5, 16'h7FF);
    cmd(2, 16'h7FF);
    cmd(31, 16'h7FF);
    rd(4'hF, v); check("R11 window kept", v, 16'd5);
    rd(4'hA, v); check("R11 imask kept", v, 16'h00A5);
    rd(4'hE, v); check("R11 status kept", v, 16'hA000);
  endtask

  task automatic t_greset;
    logic [15:0] v;
    int n;
    cmd(4, 0);
    cmd(1, 3);
    cmd(0, 16'h555);           // global reset at edge k
    cmd(1, 6);                 // edge k+1, must be ignored
    rd(4'hE, v);
    check("R10 busy", {15'b0, v[12]}, 16'h1);
    check("R10 window held", {13'b0, v[15:13]}, 16'd3);
    n = 1;
    while (n < 1000) begin
      rd(4'hE, v);
      if (!v[12]) break;
      n++;
      @(negedge clk);
    end
    check("R10 busy length", 16'(n), 16'(RC));
    rd(4'hE, v); check("R10 status after", v, 16'h0000);
    check("R10 rx cleared", {15'b0, rx_enable}, 16'h0);
    cmd(1, 5);
    rd(4'hA, v); check("R10 imask cleared", v, 16'h0);
    rd(4'h8, v); check("R10 filter cleared", v, 16'h0);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog got=timeout exp=finish");
          $display("CHECKS %0d ERRORS %0d", checks, errors);
          $finish;
        end
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_window();
    t_events_ack();
    t_irq();
    t_enables();
    t_masks();
    t_ignored();
    t_greset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule